// File: doc/BRIEF.md
# Programmable Watchdog Timer with Expiry Steering

This block is a watchdog timer driven by a 16 Hz tick strobe. Software programs a single configuration byte. Its low field is a resolution code, its middle field is a multiplier, and its top bit is a steering bit. Together they set a timeout counted in sixteenths of a second. Any write of the byte, and any read of it, services the watchdog: the count restarts from the full timeout, and the sticky expiry flag is cleared.

When the timeout runs out, the block raises its expiry flag. The steering bit then picks one of two actions:
- With the steering bit set, the block issues a one-cycle system reset request. It also wipes its own configuration to zero, which leaves the watchdog disabled, and clears the century bit it holds.
- With the steering bit clear, the block emits a one-cycle interrupt pulse. The configuration is kept, and the counter stays idle until software services the watchdog again.

The block is controlled by a three-state machine:
- `ST_IDLE`: disabled, or finished.
- `ST_RUN`: counting ticks.
- `ST_FIRE`: the single expiry cycle.

Its transitions are:
- restart with non-zero timeout: any state to `ST_RUN`.
- restart with zero timeout: any state to `ST_IDLE`.
- last tick: `ST_RUN` to `ST_FIRE`.
- expiry done: `ST_FIRE` to `ST_IDLE`.

A restart takes priority over every other transition.

Top module: `wdog_steer`

## Requirements
- R1: After a restart with resolution code r (byte bits 1:0) and multiplier m (byte bits 6:2) not zero, the expiry pulse appears exactly m*4^r ticks later. Ticks that arrive in the restart cycle itself are not counted.
- R2: A restart whose multiplier field is zero (this includes the byte value 0) disables the watchdog. No expiry pulse follows, whatever ticks arrive, and the flag stays 0.
- R3: A write stores the byte, which `rd_data` shows from the next cycle, and restarts the count from the new timeout.
- R4: A read (`rd_en`) restarts the count from the timeout of the stored byte, leaving the byte unchanged.
- R5: Every restart clears `flag_o` in the next cycle. Expiry sets `flag_o` in the same cycle as the pulse, and the flag then holds until the next restart.
- R6: On expiry with byte bit 7 set, `rst_req_o` is high for one cycle. The next cycle shows a stored byte of 0 and `cent_q` at 0.
- R7: On expiry with byte bit 7 clear, `irq_o` is high for one cycle. The byte is kept, and no further pulse occurs until a restart.
- R8: After reset, the stored byte, `flag_o`, `irq_o`, `rst_req_o` and `cent_q` are all 0.
- R9: The count advances only on cycles with `tick` high. Idle cycles between ticks neither advance nor disturb it.
- R10: `irq_o` and `rst_req_o` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 16 Hz strobe |
| wr_en | input | 1 | Write strobe for the configuration byte (restarts the count) |
| wr_data | input | 8 | Byte to write: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution |
| rd_en | input | 1 | Read strobe (restarts the count from the stored byte) |
| rd_data | output | 8 | Stored configuration byte |
| cent_we | input | 1 | Write strobe for the century bit |
| cent_d | input | 1 | Century bit value to write |
| cent_q | output | 1 | Century bit, cleared by a reset-steered expiry |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req_o | output | 1 | One-cycle system reset request on expiry |

## Verification
The embedded assertions check these properties on every cycle:
- the flag is set whenever a pulse is visible;
- a restart clears the flag;
- pulses last one cycle and never overlap;
- a zero-multiplier restart lands in the idle state;
- the count holds on cycles with no tick;
- a reset-steered expiry wipes the byte and the century bit.

Only the bench scenarios can show the exact expiry distance m*4^r. The bench sweeps every resolution and multiplier in interrupt mode, and most of them in reset mode. The scenarios also cover servicing by a read in mid-count, sparse tick patterns, and the silence of a disabled watchdog.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int DATA_W = MULT_W + RES_W + 1,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fire_clr,
    input  logic              cent_we,
    input  logic              cent_d,
    output logic [DATA_W-1:0] cfg_q,
    output logic              cent_q,
    output logic              steer,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_zero
);
    localparam int STEER_BIT = DATA_W - 1;
    localparam int MULT_LO   = RES_W;
    localparam int MULT_HI   = RES_W + MULT_W - 1;

    logic [DATA_W-1:0] src;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    logic [RES_W:0]    shamt;

    // The byte that a restart this cycle will use: a write takes priority.
    assign src   = wr_en ? wr_data : cfg_q;
    assign mult  = src[MULT_HI:MULT_LO];
    assign res   = src[RES_W-1:0];
    assign shamt = {res, 1'b0};

    assign load_val  = {{(CNT_W-MULT_W){1'b0}}, mult} << shamt;
    assign load_zero = (mult == '0);
    assign steer     = cfg_q[STEER_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end else if (fire_clr) begin
            cfg_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cent_q <= 1'b0;
        end else if (fire_clr) begin
            cent_q <= 1'b0;
        end else if (cent_we) begin
            cent_q <= cent_d;
        end
    end

    assert_fire_wipes_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_clr && !wr_en) |=> (cfg_q == '0 && !cent_q));
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic load_zero,
    input  logic tick,
    input  logic at_one,
    input  logic steer,
    output logic dec,
    output logic flag_o,
    output logic irq_o,
    output logic rst_req_o,
    output logic fire_clr
);
    wd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = load_zero ? ST_IDLE : ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_RUN:  if (tick && at_one) state_nx = ST_FIRE;
                ST_FIRE: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (restart) begin
            flag_o <= 1'b0;
        end else if (state == ST_RUN && state_nx == ST_FIRE) begin
            flag_o <= 1'b1;
        end
    end

    always_comb begin
        dec       = 1'b0;
        irq_o     = 1'b0;
        rst_req_o = 1'b0;
        fire_clr  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  dec = tick && !restart;
            ST_FIRE: begin
                irq_o     = !steer;
                rst_req_o = steer;
                fire_clr  = steer;
            end
            default: ;
        endcase
    end

    assert_flag_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || rst_req_o) |-> flag_o);
    assert_restart_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag_o);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || rst_req_o) |=> !(irq_o || rst_req_o));
    assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));
    assert_disabled_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && load_zero) |=> (state == ST_IDLE));
    assert_idle_after_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !restart) |=> (state == ST_IDLE));
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int DATA_W = MULT_W + RES_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cent_we,
    input  logic              cent_d,
    output logic              cent_q,
    output logic              flag_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

    logic             restart;
    logic             fire_clr;
    logic             steer;
    logic [CNT_W-1:0] load_val;
    logic             load_zero;
    logic             dec;
    logic             at_one;

    assign restart = wr_en || rd_en;

    wdog_cfg_reg #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .fire_clr  (fire_clr),
        .cent_we   (cent_we),
        .cent_d    (cent_d),
        .cfg_q     (rd_data),
        .cent_q    (cent_q),
        .steer     (steer),
        .load_val  (load_val),
        .load_zero (load_zero)
    );

    wdog_down_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .load_val (load_val),
        .dec      (dec),
        .at_one   (at_one)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .load_zero (load_zero),
        .tick      (tick),
        .at_one    (at_one),
        .steer     (steer),
        .dec       (dec),
        .flag_o    (flag_o),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o),
        .fire_clr  (fire_clr)
    );
endmodule

// File: tb/sim_wdog_steer.sv
`timescale 1ns/1ps
module sim_wdog_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cent_we = 1'b0;
    logic       cent_d = 1'b0;
    logic       cent_q;
    logic       flag_o;
    logic       irq_o;
    logic       rst_req_o;

    int n_checks = 0;
    int n_fail = 0;
    int at_cyc;
    int saw_irq;
    int saw_rst;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_steer u0 (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
        .cent_we (cent_we), .cent_d (cent_d), .cent_q (cent_q),
        .flag_o (flag_o), .irq_o (irq_o), .rst_req_o (rst_req_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write at one edge; ticks run continuously from the next edge.
    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b1;
    endtask

    // Count cycles (each with a tick) until a pulse; 0 if none within limit.
    task automatic measure(input int limit);
        at_cyc = 0; saw_irq = 0; saw_rst = 0;
        for (int j = 1; j <= limit; j++) begin
            @(negedge clk);
            if (irq_o || rst_req_o) begin
                at_cyc = j; saw_irq = irq_o; saw_rst = rst_req_o;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 rd_data", rd_data, 0);
        check("R8 flag", flag_o, 0);
        check("R8 irq", irq_o, 0);
        check("R8 rst_req", rst_req_o, 0);
        check("R8 cent", cent_q, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R5 R7: interrupt-mode sweep over every resolution and multiplier
        for (int r = 0; r < 4; r++) begin
            for (int m = 1; m < 32; m++) begin
                int t;
                logic [7:0] v;
                t = m * (1 << (2 * r));
                v = {1'b0, m[4:0], r[1:0]};
                do_write(v);
                check("R3 stored byte", rd_data, v);
                check("R5 flag cleared by write", flag_o, 0);
                measure(t + 3);
                check("R1 expiry distance", at_cyc, t);
                check("R7 irq not reset", saw_rst, 0);
                check("R5 flag with pulse", flag_o, 1);
                repeat (4) begin
                    @(negedge clk);
                    if (irq_o || rst_req_o) check("R7 no second pulse", 1, 0);
                end
                check("R7 byte kept", rd_data, v);
                check("R5 flag holds", flag_o, 1);
            end
        end

        // R2: multiplier zero disables, for every resolution, with steering too
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0] v;
                v = {s[0], 5'd0, r[1:0]};
                do_write(v);
                measure(300);
                check("R2 disabled no pulse", at_cyc, 0);
                check("R2 disabled flag", flag_o, 0);
            end
        end

        // R6 R10: reset-mode sweep, century bit armed first
        for (int r = 0; r < 3; r++) begin
            for (int m = 1; m < 32; m++) begin
                int t;
                t = m * (1 << (2 * r));
                @(negedge clk);
                cent_we = 1'b1; cent_d = 1'b1;
                @(negedge clk);
                cent_we = 1'b0;
                check("R6 century armed", cent_q, 1);
                do_write({1'b1, m[4:0], r[1:0]});
                measure(t + 3);
                check("R6 reset expiry distance", at_cyc, t);
                check("R10 irq not with rst_req", saw_irq, 0);
                check("R6 rst_req seen", saw_rst, 1);
                @(negedge clk);
                check("R10 rst_req one cycle", rst_req_o, 0);
                check("R6 byte wiped", rd_data, 0);
                check("R6 century cleared", cent_q, 0);
                check("R5 flag after reset expiry", flag_o, 1);
                // A read of the wiped byte stays disabled
                do_read();
                measure(50);
                check("R6 wiped byte disables", at_cyc, 0);
            end
        end

        // R9: sparse ticks, one every third cycle, timeout 5
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h14; tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        at_cyc = -1;
        for (int i = 0; i < 40; i++) begin
            if (i > 0) @(negedge clk);
            if (irq_o && at_cyc < 0) at_cyc = i;
            tick = (i % 3 == 2);
        end
        check("R9 sparse tick expiry cycle", at_cyc, 15);

        // R4: read in mid-count restarts from the stored timeout (8 ticks)
        do_write(8'h09);
        repeat (6) @(negedge clk);
        check("R4 no early pulse", irq_o, 0);
        do_read();
        check("R4 byte unchanged by read", rd_data, 8'h09);
        measure(20);
        check("R4 restart by read", at_cyc, 8);
        // R4 R5: read after expiry clears flag and rearms
        do_read();
        check("R5 flag cleared by read", flag_o, 0);
        measure(20);
        check("R4 rearm by read", at_cyc, 8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule